// File: doc/BRIEF.md
# USB Device Interrupt Flag Aggregator

This block gathers event pulses from a USB device controller into sticky status flags and turns them into a single interrupt request for the CPU's interrupt controller. Each endpoint has five flags: IN transmit done, OUT received into bank 0, OUT received into bank 1, SETUP received, and STALL handshake sent. The device has three more flags: start of frame, resume and suspend. Every flag has its own enable bit. A flag stays set until software clears it by writing 0 to its bit.

The CPU reaches the flags through a small register port with one address per register. Each endpoint has a status register and an enable register. The device has its own status and enable registers. A read-only summary register shows which endpoints have an enabled flag set, so software finds the interrupting endpoint with a single read. The request goes out only while both the USB block enable and the global enable are high. The 2-bit priority level is formed from two separate priority inputs.

Top module: `usb_irq_aggregator`

## Requirements
- R1: After reset every flag and every enable bit is 0, all registers read 0, and `irqReq` is 0.
- R2: The endpoint status register has these bits: bit 0 is IN transmit done, bit 1 is OUT in bank 0, bit 2 is OUT in bank 1, bit 3 is SETUP received and bit 4 is STALL sent. A one-cycle event pulse sets its bit on the next clock edge, and the bit stays set while no clear is written.
- R3: A bank-1 event pulse sets bit 2 only on endpoints marked ping-pong in `PINGPONG_MASK`. On single-bank endpoints the pulse is ignored and bit 2 stays 0.
- R4: A SETUP pulse clears the STALL-sent bit. When a STALL-sent pulse and a SETUP pulse arrive in the same cycle, bit 3 becomes 1 and bit 4 becomes 0.
- R5: The device status register has these bits: bit 0 is start of frame, bit 1 is resume and bit 2 is suspend. Each bit is set by its event pulse and is sticky.
- R6: A write to a status register clears every bit written as 0 and leaves every bit written as 1 unchanged. If a hardware set and a software clear hit the same bit in the same cycle, the set wins.
- R7: `irqReq` is a register. It equals the OR of all flags ANDed with their enables, ANDed with `blockEn` and `globalEn`. It follows a flag or enable change one clock later.
- R8: In the summary register, bit k is 1 exactly when endpoint k has a flag set whose enable bit is also set.
- R9: `irqLevel` equals {`prioHigh`, `prioLow`}. 00 is the lowest level and 11 is the highest.
- R10: Enable registers can be written and read back. Bits above the field width read as 0.
- R11: The register map is as follows. Address 2k is the status register of endpoint k and address 2k+1 is its enable register. Address 2·NUM_EP is the device status register, 2·NUM_EP+1 is the device enable register, and 2·NUM_EP+2 is the summary register. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| epTxDone | input | NUM_EP | IN packet accepted by host, one pulse per endpoint |
| epRxBank0 | input | NUM_EP | OUT packet stored in bank 0 |
| epRxBank1 | input | NUM_EP | OUT packet stored in bank 1 |
| epSetup | input | NUM_EP | SETUP packet accepted |
| epStallSent | input | NUM_EP | STALL handshake sent |
| devSof | input | 1 | Start-of-frame received |
| devResume | input | 1 | Resume detected after suspend |
| devSuspend | input | 1 | Bus suspend detected |
| blockEn | input | 1 | USB block interrupt enable |
| globalEn | input | 1 | Global interrupt enable |
| prioHigh | input | 1 | Priority high bit |
| prioLow | input | 1 | Priority low bit |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| irqReq | output | 1 | Registered interrupt request |
| irqLevel | output | 2 | Priority level |

## Verification
The bench fires a STALL-sent pulse and a SETUP pulse in the same cycle. A design that lets the stall set win leaves bit 4 high. It also pulses start of frame in the same cycle as a clearing write; a design that lets the clear win loses that event. A bank-1 pulse goes to a single-bank endpoint, and a design that ignores the ping-pong mask shows bit 2 set there. The bench checks `irqReq` one clock after a flag is cleared and again a clock later. A design whose request is combinational, or lags by two clocks, fails one of those two samples.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int EP_FLAGS  = 5;
  localparam int DEV_FLAGS = 3;
  localparam int DATA_W    = 8;
  localparam int MAX_EP_W  = 4;

  // endpoint flag bit positions (software decodes these)
  localparam int F_TX    = 0;
  localparam int F_RX0   = 1;
  localparam int F_RX1   = 2;
  localparam int F_SETUP = 3;
  localparam int F_STALL = 4;

  typedef enum logic [2:0] {
    RD_NONE, RD_EP_STAT, RD_EP_EN, RD_DEV_STAT, RD_DEV_EN, RD_SUMMARY
  } rdKind_e;

  typedef struct packed {
    logic                epStatWr;
    logic                epEnWr;
    logic                devStatWr;
    logic                devEnWr;
    logic [MAX_EP_W-1:0] epIdx;
    rdKind_e             rdKind;
    logic [DATA_W-1:0]   wrData;
  } ctrlStrobes_t;
endpackage

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrobes_t      strobes
);
  localparam int DEV_STAT_A = 2 * NUM_EP;
  localparam int DEV_EN_A   = DEV_STAT_A + 1;
  localparam int SUMMARY_A  = DEV_STAT_A + 2;

  logic isEp;
  assign isEp = (int'(regAddr) < DEV_STAT_A);

  always_comb begin
    strobes = '0;
    strobes.wrData = regWrData;
    strobes.epIdx  = MAX_EP_W'(regAddr >> 1);
    strobes.rdKind = RD_NONE;
    if (isEp) begin
      strobes.rdKind   = regAddr[0] ? RD_EP_EN : RD_EP_STAT;
      strobes.epStatWr = regWrEn && !regAddr[0];
      strobes.epEnWr   = regWrEn && regAddr[0];
    end else if (int'(regAddr) == DEV_STAT_A) begin
      strobes.rdKind    = RD_DEV_STAT;
      strobes.devStatWr = regWrEn;
    end else if (int'(regAddr) == DEV_EN_A) begin
      strobes.rdKind  = RD_DEV_EN;
      strobes.devEnWr = regWrEn;
    end else if (int'(regAddr) == SUMMARY_A) begin
      strobes.rdKind = RD_SUMMARY;
    end
  end
endmodule

// File: rtl/usb_irq_datapath.sv
module usb_irq_datapath
  import usb_irq_pkg::*;
#(
  parameter int              NUM_EP        = 4,
  parameter logic [NUM_EP-1:0] PINGPONG_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EP-1:0] epTxDone,
  input  logic [NUM_EP-1:0] epRxBank0,
  input  logic [NUM_EP-1:0] epRxBank1,
  input  logic [NUM_EP-1:0] epSetup,
  input  logic [NUM_EP-1:0] epStallSent,
  input  logic              devSof,
  input  logic              devResume,
  input  logic              devSuspend,
  input  logic              blockEn,
  input  logic              globalEn,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq
);
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;

  logic [EP_FLAGS-1:0]  epFlags [NUM_EP];
  logic [EP_FLAGS-1:0]  epEn    [NUM_EP];
  logic [DEV_FLAGS-1:0] devFlags, devEn;
  logic [NUM_EP-1:0]    epHit;
  logic [IDX_W-1:0]     rdIdx;

  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    logic                clrSel, enSel;
    logic [EP_FLAGS-1:0] kept, setVec, nextFlags;

    assign clrSel = strobes.epStatWr && (strobes.epIdx == MAX_EP_W'(k));
    assign enSel  = strobes.epEnWr   && (strobes.epIdx == MAX_EP_W'(k));
    assign kept   = clrSel ? (epFlags[k] & strobes.wrData[EP_FLAGS-1:0]) : epFlags[k];

    always_comb begin
      setVec          = '0;
      setVec[F_TX]    = epTxDone[k];
      setVec[F_RX0]   = epRxBank0[k];
      setVec[F_RX1]   = epRxBank1[k] && PINGPONG_MASK[k];
      setVec[F_SETUP] = epSetup[k];
      setVec[F_STALL] = epStallSent[k];
      nextFlags       = kept | setVec;
      if (epSetup[k]) nextFlags[F_STALL] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        epFlags[k] <= '0;
        epEn[k]    <= '0;
      end else begin
        epFlags[k] <= nextFlags;
        if (enSel) epEn[k] <= strobes.wrData[EP_FLAGS-1:0];
      end
    end

    assign epHit[k] = |(epFlags[k] & epEn[k]);

    assert_setup_clears_stall_R4 : assert property (@(posedge clk) disable iff (!rstN)
      epSetup[k] |=> (!epFlags[k][F_STALL] && epFlags[k][F_SETUP]));
    assert_tx_sticky_R2 : assert property (@(posedge clk) disable iff (!rstN)
      epTxDone[k] |=> epFlags[k][F_TX]);
    if (!PINGPONG_MASK[k]) begin : g_single
      assert_single_bank_R3 : assert property (@(posedge clk) disable iff (!rstN)
        epRxBank1[k] |=> !epFlags[k][F_RX1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devFlags <= '0;
      devEn    <= '0;
      irqReq   <= 1'b0;
    end else begin
      devFlags <= (strobes.devStatWr ? (devFlags & strobes.wrData[DEV_FLAGS-1:0]) : devFlags)
                | {devSuspend, devResume, devSof};
      if (strobes.devEnWr) devEn <= strobes.wrData[DEV_FLAGS-1:0];
      irqReq <= (|epHit || |(devFlags & devEn)) && blockEn && globalEn;
    end
  end

  assign rdIdx = strobes.epIdx[IDX_W-1:0];

  always_comb begin
    rdData = '0;
    case (strobes.rdKind)
      RD_EP_STAT:  rdData = DATA_W'(epFlags[rdIdx]);
      RD_EP_EN:    rdData = DATA_W'(epEn[rdIdx]);
      RD_DEV_STAT: rdData = DATA_W'(devFlags);
      RD_DEV_EN:   rdData = DATA_W'(devEn);
      RD_SUMMARY:  rdData = DATA_W'(epHit);
      default:     rdData = '0;
    endcase
  end

  assert_irq_gated_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (!blockEn || !globalEn) |=> !irqReq);
  assert_set_beats_clear_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (devSof && strobes.devStatWr) |=> devFlags[0]);
  assert_sof_sticky_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (devFlags[0] && !strobes.devStatWr) |=> devFlags[0]);
endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator
  import usb_irq_pkg::*;
#(
  parameter int                NUM_EP        = 4,
  parameter int                ADDR_W        = 4,
  parameter logic [NUM_EP-1:0] PINGPONG_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EP-1:0] epTxDone,
  input  logic [NUM_EP-1:0] epRxBank0,
  input  logic [NUM_EP-1:0] epRxBank1,
  input  logic [NUM_EP-1:0] epSetup,
  input  logic [NUM_EP-1:0] epStallSent,
  input  logic              devSof,
  input  logic              devResume,
  input  logic              devSuspend,
  input  logic              blockEn,
  input  logic              globalEn,
  input  logic              prioHigh,
  input  logic              prioLow,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              irqReq,
  output logic [1:0]        irqLevel
);
  ctrlStrobes_t strobes;

  usb_irq_ctrl #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) ctrl_i (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .strobes(strobes)
  );

  usb_irq_datapath #(.NUM_EP(NUM_EP), .PINGPONG_MASK(PINGPONG_MASK)) dp_i (
    .clk(clk), .rstN(rstN),
    .epTxDone(epTxDone), .epRxBank0(epRxBank0), .epRxBank1(epRxBank1),
    .epSetup(epSetup), .epStallSent(epStallSent),
    .devSof(devSof), .devResume(devResume), .devSuspend(devSuspend),
    .blockEn(blockEn), .globalEn(globalEn),
    .strobes(strobes), .rdData(regRdData), .irqReq(irqReq)
  );

  // R9: level 0 lowest, level 3 highest
  assign irqLevel = {prioHigh, prioLow};
endmodule

// File: tb/usb_irq_aggregator_tb_top.sv
module usb_irq_aggregator_tb_top;
  localparam int NUM_EP = 4;
  localparam int ADDR_W = 4;
  localparam logic [NUM_EP-1:0] PP = 4'b0101;

  logic clk = 0, rstN = 0;
  logic [NUM_EP-1:0] epTxDone = 0, epRxBank0 = 0, epRxBank1 = 0, epSetup = 0, epStallSent = 0;
  logic devSof = 0, devResume = 0, devSuspend = 0;
  logic blockEn = 0, globalEn = 0, prioHigh = 0, prioLow = 0;
  logic [ADDR_W-1:0] regAddr = 0;
  logic regWrEn = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic irqReq;
  logic [1:0] irqLevel;

  int testCnt = 0, failCnt = 0;

  always #4 clk = ~clk;

  usb_irq_aggregator #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .PINGPONG_MASK(PP)) dut_i (.*);

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [7:0]        exp;
    string             tag;
  } item_t;
  item_t scoreQ[$];
  int doneCnt = 0, pushCnt = 0;

  // monitor: pops expected reads and compares with the register port
  initial begin
    forever begin
      item_t it;
      wait (scoreQ.size() != 0);
      it = scoreQ.pop_front();
      @(negedge clk);
      regAddr = it.addr;
      #1;
      testCnt++;
      if (regRdData !== it.exp) begin
        failCnt++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, regRdData, it.exp);
      end
      doneCnt++;
    end
  end

  task automatic expectRead(input int addr, input logic [7:0] exp, input string tag);
    item_t it;
    it.addr = ADDR_W'(addr); it.exp = exp; it.tag = tag;
    scoreQ.push_back(it);
    pushCnt++;
    wait (doneCnt == pushCnt);
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    testCnt++;
    if (irqReq !== exp) begin
      failCnt++;
      $display("FAIL %s irqReq actual=%b expected=%b", tag, irqReq, exp);
    end
  endtask

  task automatic regWrite(input int addr, input logic [7:0] data);
    @(negedge clk);
    regAddr = ADDR_W'(addr); regWrData = data; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int DEV_S = 2 * NUM_EP, DEV_E = DEV_S + 1, SUMM = DEV_S + 2;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    expectRead(0, 8'h00, "R1 ep0 status");
    expectRead(DEV_S, 8'h00, "R1 dev status");
    expectRead(SUMM, 8'h00, "R1 summary");
    checkIrq(0, "R1 irq reset");

    // R2 transmit done on ep1, sticky
    @(negedge clk); epTxDone[1] = 1;
    @(negedge clk); epTxDone[1] = 0;
    idle(3);
    expectRead(2, 8'h01, "R2 ep1 tx sticky");
    @(negedge clk); epRxBank0[3] = 1;
    @(negedge clk); epRxBank0[3] = 0;
    expectRead(6, 8'h02, "R2 ep3 rx bank0");
    regWrite(6, 8'h00);

    // R3 bank1 on single-bank ep1 ignored, on ping-pong ep2 sets
    @(negedge clk); epRxBank1[1] = 1; epRxBank1[2] = 1;
    @(negedge clk); epRxBank1 = 0;
    expectRead(2, 8'h01, "R3 single-bank ignores bank1");
    expectRead(4, 8'h04, "R3 ping-pong bank1");

    // R4 stall then setup; and same-cycle case
    @(negedge clk); epStallSent[3] = 1;
    @(negedge clk); epStallSent[3] = 0;
    expectRead(6, 8'h10, "R4 stall set");
    @(negedge clk); epSetup[3] = 1;
    @(negedge clk); epSetup[3] = 0;
    expectRead(6, 8'h08, "R4 setup clears stall");
    @(negedge clk); epSetup[0] = 1; epStallSent[0] = 1;
    @(negedge clk); epSetup[0] = 0; epStallSent[0] = 0;
    expectRead(0, 8'h08, "R4 same-cycle setup wins");

    // R5 device flags
    @(negedge clk); devSof = 1; devResume = 1; devSuspend = 1;
    @(negedge clk); devSof = 0; devResume = 0; devSuspend = 0;
    expectRead(DEV_S, 8'h07, "R5 dev flags");

    // R6 write-0-to-clear and set wins
    regWrite(2, 8'hFE);
    expectRead(2, 8'h00, "R6 ep1 cleared");
    regWrite(DEV_S, 8'hFD);
    expectRead(DEV_S, 8'h05, "R6 clear resume only");
    @(negedge clk); regAddr = ADDR_W'(DEV_S); regWrData = 8'h00; regWrEn = 1; devSof = 1;
    @(negedge clk); regWrEn = 0; devSof = 0;
    expectRead(DEV_S, 8'h01, "R6 hw set beats clear");

    // R7 gating and one-cycle lag
    idle(2);
    checkIrq(0, "R7 no enables");
    regWrite(DEV_E, 8'h01);
    blockEn = 1; globalEn = 0;
    idle(2);
    checkIrq(0, "R7 global off");
    globalEn = 1;
    idle(2);
    checkIrq(1, "R7 both on");
    @(negedge clk); regAddr = ADDR_W'(DEV_S); regWrData = 8'h00; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
    #1 checkIrq(1, "R7 lags one cycle");
    @(negedge clk); #1 checkIrq(0, "R7 drops after clear");
    regWrite(DEV_S, 8'hFF);
    blockEn = 0;
    idle(1);

    // R10 enable read-back, R8 summary
    regWrite(7, 8'hFF);
    expectRead(7, 8'h1F, "R10 ep3 enable width");
    expectRead(DEV_E, 8'h01, "R10 dev enable");
    expectRead(SUMM, 8'h08, "R8 summary ep3 only");
    regWrite(5, 8'h04);
    expectRead(SUMM, 8'h0C, "R8 summary ep2 ep3");
    blockEn = 1;
    idle(2);
    checkIrq(1, "R7 endpoint source");
    expectRead(12, 8'h00, "R11 unmapped address");

    // R9 priority level
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); {prioHigh, prioLow} = 2'(v);
      #1 testCnt++;
      if (irqLevel !== 2'(v)) begin
        failCnt++;
        $display("FAIL R9 irqLevel actual=%0d expected=%0d", irqLevel, v);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule